// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Write Unlock

This block is a watchdog timer for a system clocked from a fixed 33 MHz reference. Once enabled, it counts down in ticks from a first preload value. When that count runs out, it can raise an interrupt and then start counting a second preload value. If software still has not restarted it when the second count runs out, it issues a one-cycle system reset pulse and records the event in a sticky status flag.

Software sets the timeout in ticks as period × 33,000,000 / divisor, with the period capped at 1000 s. The tick comes from dividing the clock by one of two divisors chosen by a configuration input: by default 32 (about 1 MHz) or 32768 (about 1 kHz).

Both preload registers and the restart/status register are protected. A write to any of them takes effect only right after a fixed two-word key has been written to the restart/status register. The enable input and the configuration inputs come from outside the block.

Top module: `wdg_two_stage`

## Requirements
- R1: After reset, the stage-1 preload reads back `PRE1_INIT` and the stage-2 preload reads back `PRE2_INIT`. The restart/status register reads 0, and both the interrupt and the reset outputs are low.
- R2: A write to a protected register takes effect only if the two writes just before it were 0x80 and then 0x86, both to the restart/status register. The register map is: offset 0 is the stage-1 preload, offset 1 is the stage-2 preload, offset 2 is restart/status. Without the key, a protected write leaves the target register unchanged.
- R3: Any write that breaks the key sequence returns the unlock logic to idle. While waiting for the second key word, any write other than 0x86 to offset 2 counts as a break, including a second 0x80.
- R4: One protected write uses up the unlock, so the next protected write needs a new key sequence.
- R5: While enabled, the countdown advances once every `DIV_FAST` clocks when `cfg_fast_tick` is 1, and once every `DIV_SLOW` clocks when it is 0.
- R6: Stage 1 runs out on the (P1+1)-th tick after enable or restart. At that point `stage1_irq` rises, unless masked, and stays high until a restart, a disable or a stage-2 expiry. The stage-2 preload is loaded at the same time.
- R7: Stage 2 runs out (P2+1) ticks after stage 1 does. `sys_rst_pulse` is then high for exactly one cycle, the interrupt drops, the timeout flag sets, and counting restarts from the stage-1 preload.
- R8: With `cfg_irq_mask` = 1, `stage1_irq` stays low, but the stage-2 reset still occurs on schedule.
- R9: An unlocked write to offset 2 with bit 8 set restarts the countdown from the stage-1 preload and clears the interrupt. Bit 8 always reads as 0.
- R10: The timeout flag reads at bit 9 of offset 2 and is sticky. Only an unlocked write to offset 2 with bit 9 set clears it. A write without the key leaves it set.
- R11: While `wd_enable` is 0, the countdown holds at the stage-1 preload and neither output asserts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 33 MHz reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register word offset |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | DATA_W | Read data for `bus_addr` (combinational) |
| cfg_fast_tick | input | 1 | 1 selects divisor `DIV_FAST`, 0 selects `DIV_SLOW` |
| cfg_irq_mask | input | 1 | 1 suppresses the stage-1 interrupt |
| wd_enable | input | 1 | Counting enable; 0 stops and re-arms the timer |
| stage1_irq | output | 1 | Stage-1 expiry interrupt (level) |
| sys_rst_pulse | output | 1 | One-cycle system reset request |

## Verification
The bench builds the block with divisors 4 and 12 and 12-bit preloads, so that a full countdown through both stages takes only tens to a few hundred clocks. This makes it possible to sweep both tick rates across several combinations of stage-1 and stage-2 preloads, including zero preloads. For every combination the bench compares the exact cycle of the interrupt and of the reset pulse against the values D·(P1+1) and D·(P1+P2+2). Because the divisor 12 is not a power of two, an off-by-one in the prescaler wrap shows up as a wrong cycle count.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
   typedef enum logic [1:0] {UL_IDLE, UL_ARMED, UL_OPEN} unlock_e;

   localparam int unsigned OFS_PRE1   = 0;
   localparam int unsigned OFS_PRE2   = 1;
   localparam int unsigned OFS_RELOAD = 2;

   localparam int unsigned KEY_FIRST  = 32'h80;
   localparam int unsigned KEY_SECOND = 32'h86;

   localparam int unsigned BIT_RESTART = 8;
   localparam int unsigned BIT_FLAG    = 9;
endpackage

// File: rtl/wdg_unlock_fsm.sv
module wdg_unlock_fsm
   import wdg_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic wr,
   input  logic key1_hit,
   input  logic key2_hit,
   output logic grant
);
   unlock_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      if (wr) begin
         unique case (state_q)
            UL_IDLE:  state_d = key1_hit ? UL_ARMED : UL_IDLE;
            UL_ARMED: state_d = key2_hit ? UL_OPEN  : UL_IDLE;
            default:  state_d = UL_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= UL_IDLE;
      else        state_q <= state_d;
   end

   assign grant = wr && (state_q == UL_OPEN);

   // R4: a write in the open state always closes the unlock
   p_open_consumed_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && state_q == UL_OPEN) |=> (state_q == UL_IDLE));
   // R2: a grant is only possible after the second key was accepted
   p_grant_after_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
      grant |-> ($past(state_q) == UL_ARMED || $past(state_q) == UL_OPEN));
   // R3: a non-key write while armed drops back to idle
   p_break_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && state_q == UL_ARMED && !key2_hit) |=> (state_q == UL_IDLE));
endmodule

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
   parameter int unsigned DIV_FAST = 32,
   parameter int unsigned DIV_SLOW = 32768
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic clr,
   input  logic fast,
   output logic tick
);
   localparam int unsigned MAX_DIV = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
   localparam int unsigned CW      = $clog2(MAX_DIV);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] limit;

   assign limit = fast ? CW'(DIV_FAST - 1) : CW'(DIV_SLOW - 1);
   assign tick  = en && !clr && (cnt_q == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (!en || clr)    cnt_q <= '0;
      else if (cnt_q == limit) cnt_q <= '0;
      else                    cnt_q <= cnt_q + 1'b1;
   end

   // R5: each tick is followed by a fresh prescaler period
   p_tick_wraps_r5: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (cnt_q == '0));
   // R11: no tick while disabled
   p_no_tick_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> !tick);
endmodule

// File: rtl/wdg_countdown.sv
module wdg_countdown #(
   parameter int unsigned PRE_W     = 30,
   parameter int unsigned PRE1_INIT = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             tick,
   input  logic             restart,
   input  logic             irq_mask,
   input  logic [PRE_W-1:0] pre1,
   input  logic [PRE_W-1:0] pre2,
   output logic             irq,
   output logic             rst_pulse
);
   logic             stage2_q;
   logic [PRE_W-1:0] cnt_q;
   logic             irq_q;
   logic             rstp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage2_q <= 1'b0;
         cnt_q    <= PRE_W'(PRE1_INIT);
         irq_q    <= 1'b0;
         rstp_q   <= 1'b0;
      end else begin
         rstp_q <= 1'b0;
         if (!en || restart) begin
            stage2_q <= 1'b0;
            cnt_q    <= pre1;
            irq_q    <= 1'b0;
         end else if (tick) begin
            if (cnt_q != '0) begin
               cnt_q <= cnt_q - 1'b1;
            end else if (!stage2_q) begin
               stage2_q <= 1'b1;
               cnt_q    <= pre2;
               if (!irq_mask) irq_q <= 1'b1;
            end else begin
               stage2_q <= 1'b0;
               cnt_q    <= pre1;
               irq_q    <= 1'b0;
               rstp_q   <= 1'b1;
            end
         end
      end
   end

   assign irq       = irq_q;
   assign rst_pulse = rstp_q;

   // R7: reset request lasts one cycle
   p_rst_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rst_pulse |=> !rst_pulse);
   // R8: interrupt only rises when unmasked
   p_irq_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> !$past(irq_mask));
   // R11: disabled timer stays quiet
   p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!irq && !rst_pulse));
   // R9: restart drops the interrupt
   p_restart_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !irq);
endmodule

// File: rtl/wdg_two_stage.sv
module wdg_two_stage
   import wdg_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned PRE_W     = 30,
   parameter int unsigned DIV_FAST  = 32,
   parameter int unsigned DIV_SLOW  = 32768,
   parameter int unsigned PRE1_INIT = 1031250,
   parameter int unsigned PRE2_INIT = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_we,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              cfg_fast_tick,
   input  logic              cfg_irq_mask,
   input  logic              wd_enable,
   output logic              stage1_irq,
   output logic              sys_rst_pulse
);
   generate
      if (DATA_W <= BIT_FLAG) begin : g_bad_data_w
         $error("DATA_W must exceed the status flag bit position");
      end
      if (PRE_W > DATA_W || PRE_W < 1) begin : g_bad_pre_w
         $error("PRE_W must lie between 1 and DATA_W");
      end
      if (DIV_FAST < 2 || DIV_SLOW < DIV_FAST) begin : g_bad_div
         $error("divisors need 2 <= DIV_FAST <= DIV_SLOW");
      end
      if (ADDR_W < 2) begin : g_bad_addr_w
         $error("ADDR_W must cover three registers");
      end
   endgenerate

   logic             sel_pre1, sel_pre2, sel_rld;
   logic             grant, restart;
   logic             tick;
   logic [PRE_W-1:0] pre1_q, pre2_q;
   logic             flag_q;
   logic [DATA_W-1:0] pre1_ext, pre2_ext;

   assign sel_pre1 = (bus_addr == ADDR_W'(OFS_PRE1));
   assign sel_pre2 = (bus_addr == ADDR_W'(OFS_PRE2));
   assign sel_rld  = (bus_addr == ADDR_W'(OFS_RELOAD));

   wdg_unlock_fsm u_unlock (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (bus_we),
      .key1_hit (sel_rld && bus_wdata == DATA_W'(KEY_FIRST)),
      .key2_hit (sel_rld && bus_wdata == DATA_W'(KEY_SECOND)),
      .grant    (grant)
   );

   assign restart = grant && sel_rld && bus_wdata[BIT_RESTART];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre1_q <= PRE_W'(PRE1_INIT);
         pre2_q <= PRE_W'(PRE2_INIT);
         flag_q <= 1'b0;
      end else begin
         if (grant && sel_pre1) pre1_q <= bus_wdata[PRE_W-1:0];
         if (grant && sel_pre2) pre2_q <= bus_wdata[PRE_W-1:0];
         if (sys_rst_pulse)
            flag_q <= 1'b1;
         else if (grant && sel_rld && bus_wdata[BIT_FLAG])
            flag_q <= 1'b0;
      end
   end

   wdg_prescaler #(
      .DIV_FAST (DIV_FAST),
      .DIV_SLOW (DIV_SLOW)
   ) u_presc (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (wd_enable),
      .clr   (restart),
      .fast  (cfg_fast_tick),
      .tick  (tick)
   );

   wdg_countdown #(
      .PRE_W     (PRE_W),
      .PRE1_INIT (PRE1_INIT)
   ) u_count (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (wd_enable),
      .tick      (tick),
      .restart   (restart),
      .irq_mask  (cfg_irq_mask),
      .pre1      (pre1_q),
      .pre2      (pre2_q),
      .irq       (stage1_irq),
      .rst_pulse (sys_rst_pulse)
   );

   generate
      if (PRE_W < DATA_W) begin : g_ext
         assign pre1_ext = {{(DATA_W-PRE_W){1'b0}}, pre1_q};
         assign pre2_ext = {{(DATA_W-PRE_W){1'b0}}, pre2_q};
      end else begin : g_full
         assign pre1_ext = pre1_q;
         assign pre2_ext = pre2_q;
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      if (sel_pre1)      bus_rdata = pre1_ext;
      else if (sel_pre2) bus_rdata = pre2_ext;
      else if (sel_rld)  bus_rdata[BIT_FLAG] = flag_q;
   end

   // R2: writes without the key leave the preloads untouched
   p_locked_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && !grant) |=> ($stable(pre1_q) && $stable(pre2_q)));
   // R7: a reset request always leaves the flag set
   p_rst_sets_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst_pulse |=> flag_q);
   // R10: the flag only falls through an unlocked clear
   p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_q) |-> $past(grant && sel_rld && bus_wdata[BIT_FLAG]));
endmodule

// File: tb/wdg_two_stage_tb_top.sv
module wdg_two_stage_tb_top;
   localparam int unsigned DW = 32;
   localparam int unsigned AW = 4;
   localparam int unsigned PW = 12;
   localparam int unsigned DF = 4;
   localparam int unsigned DS = 12;
   localparam int unsigned P1I = 'h0FF;
   localparam int unsigned P2I = 'h2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic          bus_we = 1'b0;
   logic [DW-1:0] bus_rdata;
   logic          cfg_fast_tick = 1'b1;
   logic          cfg_irq_mask = 1'b0;
   logic          wd_enable = 1'b0;
   logic          stage1_irq;
   logic          sys_rst_pulse;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   wdg_two_stage #(
      .DATA_W (DW), .ADDR_W (AW), .PRE_W (PW),
      .DIV_FAST (DF), .DIV_SLOW (DS),
      .PRE1_INIT (P1I), .PRE2_INIT (P2I)
   ) dut_i (
      .clk (clk), .rst_n (rst_n),
      .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_we (bus_we),
      .bus_rdata (bus_rdata),
      .cfg_fast_tick (cfg_fast_tick), .cfg_irq_mask (cfg_irq_mask),
      .wd_enable (wd_enable),
      .stage1_irq (stage1_irq), .sys_rst_pulse (sys_rst_pulse)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = AW'(a); bus_wdata = d; bus_we = 1'b1;
      @(posedge clk);
      #1 bus_we = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = AW'(a);
      #1 d = bus_rdata;
   endtask

   task automatic uwr(input int a, input logic [31:0] d);
      wr(2, 32'h80);
      wr(2, 32'h86);
      wr(a, d);
   endtask

   task automatic run_case(input bit fast, input int p1, input int p2, input bit mask);
      int n, irq_n, dv;
      bit irq_seen;
      logic [31:0] v;
      @(negedge clk);
      wd_enable = 1'b0; cfg_fast_tick = fast; cfg_irq_mask = mask;
      uwr(0, p1);
      uwr(1, p2);
      uwr(2, 32'h200);
      dv = fast ? DF : DS;
      @(negedge clk);
      wd_enable = 1'b1;
      n = 0; irq_n = 0; irq_seen = 1'b0;
      while (n < 3000) begin
         @(posedge clk); n++;
         #1;
         if (stage1_irq && !irq_seen) begin irq_seen = 1'b1; irq_n = n; end
         if (sys_rst_pulse) break;
      end
      if (!mask) chk("R6 irq cycle (R5 rate)", irq_n, dv*(p1+1));
      else       chk("R8 irq masked", {31'b0, irq_seen}, 0);
      chk("R7 reset cycle (R5 rate)", n, dv*(p1+p2+2));
      @(posedge clk); #1;
      chk("R7 reset one cycle", {31'b0, sys_rst_pulse}, 0);
      chk("R7 irq dropped", {31'b0, stage1_irq}, 0);
      rd(2, v);
      chk("R10 flag set", v, 32'h200);
      @(negedge clk);
      wd_enable = 1'b0;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         fails++; tests++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      int n;
      bit hit;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      rd(0, v); chk("R1 pre1 init", v, P1I);
      rd(1, v); chk("R1 pre2 init", v, P2I);
      rd(2, v); chk("R1 status zero", v, 0);
      chk("R1 irq low", {31'b0, stage1_irq}, 0);
      chk("R1 rst low", {31'b0, sys_rst_pulse}, 0);

      // R2 locked write ignored
      wr(0, 32'h55);
      rd(0, v); chk("R2 locked write ignored", v, P1I);

      // R3 broken sequences
      wr(2, 32'h80); wr(0, 32'h66); wr(2, 32'h86); wr(0, 32'h66);
      rd(0, v); chk("R3 interleaved write breaks key", v, P1I);
      wr(2, 32'h80); wr(2, 32'h80); wr(2, 32'h86); wr(0, 32'h67);
      rd(0, v); chk("R3 repeated first key breaks", v, P1I);

      // R2 valid unlock, R4 consumption
      uwr(0, 32'h21);
      rd(0, v); chk("R2 unlocked write lands", v, 32'h21);
      wr(1, 32'h7);
      rd(1, v); chk("R4 unlock consumed", v, P2I);

      // R9 restart
      @(negedge clk);
      cfg_fast_tick = 1'b1; cfg_irq_mask = 1'b0;
      uwr(0, 5); uwr(1, 50);
      @(negedge clk); wd_enable = 1'b1;
      repeat (10) @(posedge clk);
      #1 chk("R9 no irq yet", {31'b0, stage1_irq}, 0);
      uwr(2, 32'h100);
      n = 0;
      while (n < 500 && !stage1_irq) begin
         @(posedge clk); n++; #1;
      end
      chk("R9 restart count", n, DF*6);
      uwr(2, 32'h100);
      chk("R9 restart clears irq", {31'b0, stage1_irq}, 0);
      rd(2, v); chk("R9 restart bit reads zero", v, 0);

      // R11 disabled holds
      @(negedge clk); wd_enable = 1'b0;
      hit = 1'b0;
      repeat (400) begin
         @(posedge clk); #1;
         if (stage1_irq || sys_rst_pulse) hit = 1'b1;
      end
      chk("R11 disabled quiet", {31'b0, hit}, 0);

      // R5..R8 sweep
      for (int f = 0; f < 2; f++)
         for (int a = 0; a < 3; a++)
            for (int b = 0; b < 2; b++)
               run_case(f[0], (a == 2) ? 3 : a, b*2, (a == 1));

      // R10 sticky flag
      wr(2, 32'h200);
      rd(2, v); chk("R10 locked clear ignored", v, 32'h200);
      uwr(2, 32'h200);
      rd(2, v); chk("R10 unlocked clear", v, 0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule